// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Serial Result Output

This block is the digital control side of a 12-bit successive-approximation converter. The host drives a serial clock (`clk`) and an active-low select (`cs_n`). Each frame starts when select goes low after a long enough deselect interval. A frame lasts 16 clocks. The first four are a sample/hold phase with `sample_hold` high. The remaining twelve each resolve one result bit, most significant first, by presenting a trial code on `dac_code` and reading back the single-bit comparator input `cmp_ge`.

While the current sample is being resolved, the result of the previous completed frame is shifted out on `sdata`, MSB first. The data pin therefore runs one sample behind the conversion. When the last bit decision completes, `conv_done` pulses once and the new word is latched for the next frame's serial output. `signed_mode` picks offset-binary or two's-complement coding of that word.

The host paces everything through its clock, and there is no back-pressure: a frame either completes in 16 clocks or is abandoned when select rises early. The analog array, comparator and sampling switch sit outside the block.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset, `sdata`, `conv_done` and `sample_hold` are 0, and `dac_code` and `conv_result` are all zeros.
- R2: A frame starts on a rising edge that samples `cs_n` low, but only if `cs_n` was sampled high on at least 2 consecutive edges just before it, counted since reset or since the previous frame ended or was abandoned. If `cs_n` goes low with fewer high edges than that, it is ignored until `cs_n` is high again.
- R3: Frame cycles 0 to 3 (the cycles after the start edge) are the sample/hold phase: `sample_hold` is 1 and `dac_code` is 0.
- R4: In frame cycle c, for c from 4 to 15, the bit under test is b = 15 - c. `dac_code` equals the bits already decided above b, with bit b set and all lower bits clear. On the edge that ends the cycle, bit b is kept when `cmp_ge` is 1 and cleared otherwise.
- R5: `conv_done` is high for exactly one cycle, the cycle after the edge that ends frame cycle 15. In that same cycle `conv_result` holds the new word. With a comparator that reports input >= trial code, the unsigned word equals the held input code.
- R6: With `signed_mode` = 0 the word is offset binary (the search result unchanged). With `signed_mode` = 1 its bit 11 is inverted, so mid-scale 0x800 gives 0x000 and 0x7FF gives 0xFFF. `signed_mode` is sampled on the completing edge.
- R7: In frame cycle c, for c from 0 to 11, `sdata` carries bit 11 - c of the word from the last completed frame. Outside those cycles `sdata` is 0.
- R8: If `cs_n` is sampled high on any edge ending frame cycles 0 to 15, the frame is abandoned. There is no `conv_done`, `conv_result` keeps its value, `sdata`, `sample_hold` and `dac_code` go to 0 in the next cycle, and the next frame shifts out the same earlier word.
- R9: After a completed frame, holding `cs_n` low starts no new frame until `cs_n` has again been high for 2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| signed_mode | input | 1 | 1: two's-complement word, 0: offset binary |
| cmp_ge | input | 1 | Comparator: 1 when held input is at or above `dac_code` |
| sample_hold | output | 1 | High during the sample/hold phase |
| dac_code | output | 12 | Trial code for the capacitive array |
| sdata | output | 1 | Serial data, previous word, MSB first |
| conv_done | output | 1 | One-cycle pulse when a word completes |
| conv_result | output | 12 | Last completed word |

## Verification
The bench targets the edges of the frame. An off-by-one in the sample/hold length would shift every trial code by a cycle and break the per-cycle `dac_code` checks. Serializing the current word instead of the previous one, or starting one bit late, would corrupt the MSB-first stream compared against the last completed word. Early select release is tested during both the sample and bit-cycling phases, because a design that latched a partial word or pulsed done would change the next frame's serial data. A one-edge deselect and a select held low past frame end are also tested; a design that restarts on them would raise `sample_hold`. Full-scale, zero, mid-scale and the signed MSB inversion probe the result coding.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RUN     = 2'd1,
    PH_HOLDOFF = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
  import sar_seq_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int MIN_DESEL = 2,
  parameter int CYC_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  output logic             run,
  output logic [CYC_W-1:0] cyc,
  output logic             start,
  output logic             step,
  output logic             abort,
  output logic             last
);
  localparam int DESEL_W = $clog2(MIN_DESEL + 1);
  localparam logic [DESEL_W-1:0] DESEL_MAX = DESEL_W'(MIN_DESEL);
  localparam logic [DESEL_W-1:0] DESEL_ONE = DESEL_W'(1);
  localparam logic [CYC_W-1:0]   CYC_LAST  = CYC_W'(FRAME_LEN - 1);

  phase_e             ph_q;
  logic [CYC_W-1:0]   cyc_q;
  logic [DESEL_W-1:0] desel_q;

  assign run   = (ph_q == PH_RUN);
  assign cyc   = cyc_q;
  assign start = (ph_q == PH_IDLE) && !cs_n && (desel_q == DESEL_MAX);
  assign step  = run && !cs_n;
  assign abort = run && cs_n;
  assign last  = step && (cyc_q == CYC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cyc_q   <= '0;
      desel_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (cs_n) begin
            if (desel_q != DESEL_MAX) desel_q <= desel_q + DESEL_ONE;
          end else if (desel_q == DESEL_MAX) begin
            ph_q  <= PH_RUN;
            cyc_q <= '0;
          end else begin
            ph_q    <= PH_HOLDOFF;
            desel_q <= '0;
          end
        end
        PH_RUN: begin
          if (cs_n) begin
            ph_q    <= PH_IDLE;
            desel_q <= DESEL_ONE;
            cyc_q   <= '0;
          end else if (cyc_q == CYC_LAST) begin
            ph_q    <= PH_HOLDOFF;
            desel_q <= '0;
            cyc_q   <= '0;
          end else begin
            cyc_q <= cyc_q + CYC_W'(1);
          end
        end
        default: begin
          if (cs_n) begin
            ph_q    <= PH_IDLE;
            desel_q <= DESEL_ONE;
          end
        end
      endcase
    end
  end

  // R2: a frame only begins after select was seen high on the previous edge
  assert_start_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(cs_n));

  // R8: early release leaves the frame on the next edge
  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !run);

  // R9: select held low after a frame never restarts it
  assert_holdoff_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HOLDOFF && !cs_n) |=> !run);
endmodule

// File: rtl/sar_bit_core.sv
module sar_bit_core #(
  parameter int RES_W    = 12,
  parameter int HOLD_LEN = 4,
  parameter int CYC_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CYC_W-1:0] cyc,
  input  logic             start,
  input  logic             step,
  input  logic             cmp_ge,
  output logic             sampling,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] code_next
);
  localparam logic [CYC_W-1:0] HOLD_END = CYC_W'(HOLD_LEN);

  logic [RES_W-1:0] probe;
  logic [RES_W-1:0] sar_q;
  logic [RES_W-1:0] sar_d;

  for (genvar i = 0; i < RES_W; i++) begin : g_probe
    assign probe[i] = run && (cyc == CYC_W'(HOLD_LEN + RES_W - 1 - i));
  end

  assign sampling  = run && (cyc < HOLD_END);
  assign sar_d     = (sar_q & ~probe) | (cmp_ge ? probe : '0);
  assign code_next = sar_d;
  assign dac_code  = run ? (sar_q | probe) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sar_q <= '0;
    else if (start) sar_q <= '0;
    else if (step)  sar_q <= sar_d;
  end

  for (genvar i = 1; i < RES_W; i++) begin : g_chk
    // R4: the decided bit follows the comparator on the next trial code
    assert_keep_on_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && probe[i]) |=> (dac_code[i] == $past(cmp_ge)));
  end
endmodule

// File: rtl/sar_out_ser.sv
module sar_out_ser #(
  parameter int RES_W = 12,
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic             abort,
  input  logic             last,
  input  logic [CYC_W-1:0] cyc,
  input  logic             signed_mode,
  input  logic [RES_W-1:0] code_next,
  output logic             sdata,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam logic [CYC_W-1:0] SHIFT_END = CYC_W'(RES_W - 1);
  localparam logic [RES_W-1:0] MSB_FLIP  = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] word_q;
  logic [RES_W-1:0] sh_q;
  logic             sdata_q;
  logic             done_q;

  assign sdata  = sdata_q;
  assign done   = done_q;
  assign result = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      sh_q    <= '0;
      sdata_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (last) word_q <= signed_mode ? (code_next ^ MSB_FLIP) : code_next;
      if (start) begin
        sdata_q <= word_q[RES_W-1];
        sh_q    <= word_q << 1;
      end else if (abort) begin
        sdata_q <= 1'b0;
      end else if (step && (cyc < SHIFT_END)) begin
        sdata_q <= sh_q[RES_W-1];
        sh_q    <= sh_q << 1;
      end else begin
        sdata_q <= 1'b0;
      end
    end
  end

  // R5: the completion strobe never lasts two cycles
  assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: an abandoned frame keeps the stored word and parks the line
  assert_abort_holds_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ($stable(word_q) && !sdata_q && !done_q));
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer #(
  parameter int RES_W     = 12,
  parameter int FRAME_LEN = 16,
  parameter int MIN_DESEL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             signed_mode,
  input  logic             cmp_ge,
  output logic             sample_hold,
  output logic [RES_W-1:0] dac_code,
  output logic             sdata,
  output logic             conv_done,
  output logic [RES_W-1:0] conv_result
);
  localparam int CYC_W    = $clog2(FRAME_LEN);
  localparam int HOLD_LEN = FRAME_LEN - RES_W;

  logic             run, start, step, abort, last;
  logic [CYC_W-1:0] cyc;
  logic [RES_W-1:0] code_next;

  sar_frame_ctrl #(
    .FRAME_LEN(FRAME_LEN), .MIN_DESEL(MIN_DESEL), .CYC_W(CYC_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .run(run), .cyc(cyc),
    .start(start), .step(step), .abort(abort), .last(last)
  );

  sar_bit_core #(
    .RES_W(RES_W), .HOLD_LEN(HOLD_LEN), .CYC_W(CYC_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .cyc(cyc), .start(start),
    .step(step), .cmp_ge(cmp_ge), .sampling(sample_hold),
    .dac_code(dac_code), .code_next(code_next)
  );

  sar_out_ser #(
    .RES_W(RES_W), .CYC_W(CYC_W)
  ) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .abort(abort),
    .last(last), .cyc(cyc), .signed_mode(signed_mode), .code_next(code_next),
    .sdata(sdata), .done(conv_done), .result(conv_result)
  );

  // R3: no trial code is driven while the input is being sampled
  assert_quiet_dac_in_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> (dac_code == '0));
endmodule

// File: tb/sar_conv_sequencer_test.sv
module sar_conv_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        signed_mode = 1'b0;
  logic        cmp_ge;
  logic        sample_hold;
  logic [11:0] dac_code;
  logic        sdata;
  logic        conv_done;
  logic [11:0] conv_result;

  logic [11:0] vin = '0;
  logic [11:0] held = '0;
  logic [11:0] prev_word = '0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // behavioural comparator stub
  always @(posedge clk) if (sample_hold) held <= vin;
  assign cmp_ge = (held >= dac_code);

  sar_conv_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .signed_mode(signed_mode),
    .cmp_ge(cmp_ge), .sample_hold(sample_hold), .dac_code(dac_code),
    .sdata(sdata), .conv_done(conv_done), .conv_result(conv_result)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk(req, "sample_hold", int'(sample_hold), 0);
    chk(req, "dac_code", int'(dac_code), 0);
    chk(req, "conv_done", int'(conv_done), 0);
    chk(req, "sdata", int'(sdata), 0);
  endtask

  // one full frame; called at a negedge with two high select edges behind it
  task automatic run_frame(input int v, input bit sm, input int extra_low);
    int expw;
    vin = 12'(v);
    signed_mode = sm;
    cs_n = 1'b0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (c < 4) begin
        chk("R3", "sample_hold", int'(sample_hold), 1);
        chk("R3", "dac_code", int'(dac_code), 0);
      end else begin
        int b = 15 - c;
        int e = (v & ~((1 << (b + 1)) - 1)) | (1 << b);
        chk("R4", "dac_code", int'(dac_code), e & 12'hFFF);
        chk("R4", "sample_hold", int'(sample_hold), 0);
      end
      chk("R7", "sdata", int'(sdata), (c < 12) ? int'(prev_word[11-c]) : 0);
      chk("R5", "early conv_done", int'(conv_done), 0);
    end
    @(negedge clk);
    expw = sm ? (v ^ 12'h800) : v;
    chk("R5", "conv_done", int'(conv_done), 1);
    chk(sm ? "R6" : "R5", "conv_result", int'(conv_result), expw);
    prev_word = 12'(expw);
    for (int k = 0; k < extra_low; k++) begin
      @(negedge clk);
      quiet("R9");
    end
    cs_n = 1'b1;
    @(negedge clk);
    chk("R5", "single pulse", int'(conv_done), 0);
    @(negedge clk);
  endtask

  // abandons a frame after k observed cycles
  task automatic abort_frame(input int v, input int k, input bit early);
    vin = 12'(v);
    cs_n = 1'b0;
    for (int c = 0; c < k; c++) begin
      @(negedge clk);
      chk("R7", "sdata before abort", int'(sdata), (c < 12) ? int'(prev_word[11-c]) : 0);
    end
    cs_n = 1'b1;
    @(negedge clk);
    quiet("R8");
    chk("R8", "conv_result kept", int'(conv_result), int'(prev_word));
    if (early) begin
      cs_n = 1'b0;
    end else begin
      @(negedge clk);
      chk("R8", "no late done", int'(conv_done), 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    quiet("R1");
    chk("R1", "conv_result", int'(conv_result), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_unsigned();
    run_frame(12'h5A3, 1'b0, 0);
    run_frame(12'hFFF, 1'b0, 0);
    run_frame(12'h000, 1'b0, 0);
    run_frame(12'h800, 1'b0, 0);
  endtask

  task automatic t_signed();
    run_frame(12'h800, 1'b1, 0);
    run_frame(12'h7FF, 1'b1, 0);
    run_frame(12'h2C7, 1'b1, 0);
  endtask

  task automatic t_abort();
    abort_frame(12'h111, 9, 1'b0);
    abort_frame(12'h222, 2, 1'b0);
    run_frame(12'h3C4, 1'b0, 0);
  endtask

  task automatic t_short_deselect();
    abort_frame(12'h0AA, 5, 1'b1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      quiet("R2");
    end
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(12'hA5A, 1'b0, 0);
  endtask

  task automatic t_stay_low();
    run_frame(12'h0F0, 1'b0, 20);
    run_frame(12'h123, 1'b1, 0);
  endtask

  initial begin
    t_reset();
    t_unsigned();
    t_signed();
    t_abort();
    t_short_deselect();
    t_stay_low();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule